// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

The block keeps wall-clock time as packed two-digit BCD bytes: seconds, minutes, hours, day of month, month and a two-digit year, plus a three-bit weekday. A single-cycle 1 Hz tick advances the time by one second whenever the run bit is set. The carry chain follows the calendar: minute and hour rollover, the length of each month, leap Februaries, the month-to-year carry and the year wrap from 99 to 00. Hours count either 00 to 23 or 12-hour style with a PM flag.

Software reaches the block through a byte-wide register port with a write strobe and a combinational read path. To set the time, software clears the run bit, writes every field, then sets the run bit again. Counting cannot disturb the fields in between. To read the time, software sets the snapshot bit. On the next clock edge the six date and time counters are copied into static latches, and reads of the low six offsets always return those latches. A multi-byte read is therefore coherent even if a tick arrives halfway through it.

Top module: `bcd_calendar_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the time is 00:00:00, the day is 01, the month is 01, the year is 00 and the weekday is 0. The latches hold the same values, and run, 12-hour mode and snapshot are all 0.
- R2: The counters change only on a clock edge where tick_1hz is 1 and the run bit (bit 0 of the control register at offset 0x0D) is 1. Seconds and minutes count 00 to 59 in BCD, and each carries into the next field on wrapping.
- R3: With bit 3 of the control register at 0, hours count 00 to 23, and the wrap from 23 to 00 advances the day.
- R4: With bit 3 of the control register at 1, bit 7 of the hours byte is the PM flag and bits 6:0 count 12, 01 … 11 in BCD. The step from 11 to 12 toggles PM. Only the step from 11 PM to 12 AM advances the day.
- R5: The day returns to 01 after day 31, or after day 30 for months 04, 06, 09 and 11. February ends after day 29 when the binary value of the year is divisible by 4 (including 00), and after day 28 otherwise.
- R6: A day rollover advances the month, which runs 01 to 12. The month wrap from 12 to 01 advances the year, which runs 00 to 99 and wraps from 99 to 00.
- R7: The weekday, at offset 0x06 bits 2:0 with bits 7:3 reading 0, advances at every day rollover and wraps from 6 to 0.
- R8: A write to offsets 0x00 to 0x06 while the run bit is 0 takes effect at that clock edge, with offset 0x06 storing only bits 2:0. The same write while the run bit is 1 is ignored.
- R9: Writing 1 to bit 6 of the control register makes the following clock edge copy the live seconds through year into the latches. The copy takes the values from before any tick at that edge. Reads of offsets 0x00 to 0x05 always return the latches, which hold until the next snapshot.
- R10: Bit 6 of the control register reads 1 for exactly the one cycle after it was written as 1, then reads 0. Bits 0 and 3 read back as written, and the other bits read 0.
- R11: Bit 1 of the status register at offset 0x0E reads the run bit, and its other bits read 0. Any offset other than 0x00–0x06, 0x0D and 0x0E reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse per second |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
Two functions can meet at the same edge: a snapshot capture and a counting tick. In that case the latches must receive the time from before the increment. The bench provokes this by writing the snapshot bit and then pulsing the tick in the very next cycle, at a moment when the seconds are about to carry into minutes and hours. A second collision is a tick that arrives in the same cycle as a control write that stops the counter. That tick must still count, because it is judged against the run bit that was in force before the edge. A behavioural model advances the calendar in plain integers and predicts the read data at every clock, so either collision shows up as a mismatch on the next read of the latches.

// File: rtl/calendar_pkg.sv
// Shared constants, the time record and BCD helper functions for the
// calendar counter. Assumes every byte holds two-digit packed BCD.
package calendar_pkg;
    localparam int DATA_W      = 8;
    localparam int NUM_FIELDS  = 7;   // sec, min, hour, day, month, year, weekday
    localparam int NUM_SHADOW  = 6;   // fields copied by a snapshot
    localparam int SHADOW_W    = NUM_SHADOW * DATA_W;
    localparam int WDAY_W      = 3;

    localparam int OFS_WDAY    = 6;
    localparam int OFS_CTRL    = 13;
    localparam int OFS_STAT    = 14;

    localparam int CTL_RUN     = 0;
    localparam int CTL_MODE12  = 3;
    localparam int CTL_SNAP    = 6;
    localparam int STS_RUNNING = 1;

    // Field order makes bits [47:0] equal {year, month, day, hour, min, sec}
    typedef struct packed {
        logic [WDAY_W-1:0] wday;
        logic [7:0]        year;
        logic [7:0]        mon;
        logic [7:0]        day;
        logic [7:0]        hour;
        logic [7:0]        min;
        logic [7:0]        sec;
    } cal_time_t;

    localparam cal_time_t TIME_RESET = '{wday: '0, year: 8'h00, mon: 8'h01,
                                         day: 8'h01, hour: 8'h00, min: 8'h00,
                                         sec: 8'h00};

    // Adds one to a two-digit BCD byte
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // True when the BCD year value is a multiple of four
    function automatic logic bcd_leap(input logic [7:0] y);
        if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Final day of a BCD month
    function automatic logic [7:0] last_day(input logic [7:0] m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/cal_time_core.sv
// Live calendar counters with the full BCD carry chain.
// Assumes the caller never asserts advance and a load in the same cycle.
// Out-of-range values are wrapped at the next carry by >= compares.
module cal_time_core
    import calendar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  advance,
    input  logic                  mode12,
    input  logic [NUM_FIELDS-1:0] load_en,
    input  logic [DATA_W-1:0]     load_data,
    output cal_time_t             now
);
    cal_time_t nxt;

    // Next-second value of every field
    always_comb begin
        logic c_min, c_hr, c_day, c_mon;
        nxt   = now;
        c_min = now.sec >= 8'h59;
        c_hr  = c_min && (now.min >= 8'h59);
        c_day = 1'b0;
        c_mon = 1'b0;
        nxt.sec = c_min ? 8'h00 : bcd_inc(now.sec);
        if (c_min) nxt.min = (now.min >= 8'h59) ? 8'h00 : bcd_inc(now.min);
        if (c_hr) begin
            if (mode12) begin
                if (now.hour[6:0] == 7'h11) begin
                    nxt.hour = {~now.hour[7], 7'h12};
                    c_day    = now.hour[7];
                end else if (now.hour[6:0] >= 7'h12) begin
                    nxt.hour = {now.hour[7], 7'h01};
                end else begin
                    nxt.hour = {now.hour[7], bcd_inc({1'b0, now.hour[6:0]})};
                    nxt.hour[7] = now.hour[7];
                end
            end else begin
                c_day    = now.hour >= 8'h23;
                nxt.hour = c_day ? 8'h00 : bcd_inc(now.hour);
            end
        end
        if (c_day) begin
            nxt.wday = (now.wday >= WDAY_W'(6)) ? '0 : now.wday + WDAY_W'(1);
            c_mon    = now.day >= last_day(now.mon, bcd_leap(now.year));
            nxt.day  = c_mon ? 8'h01 : bcd_inc(now.day);
        end
        if (c_mon) begin
            nxt.mon = (now.mon >= 8'h12) ? 8'h01 : bcd_inc(now.mon);
            if (now.mon >= 8'h12) nxt.year = (now.year >= 8'h99) ? 8'h00 : bcd_inc(now.year);
        end
    end

    // Counter register: reset, tick advance or per-field software load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= TIME_RESET;
        end else if (advance) begin
            now <= nxt;
        end else begin
            if (load_en[0]) now.sec  <= load_data;
            if (load_en[1]) now.min  <= load_data;
            if (load_en[2]) now.hour <= load_data;
            if (load_en[3]) now.day  <= load_data;
            if (load_en[4]) now.mon  <= load_data;
            if (load_en[5]) now.year <= load_data;
            if (load_en[6]) now.wday <= load_data[WDAY_W-1:0];
        end
    end
endmodule

// File: rtl/cal_shadow.sv
// Static byte latches loaded from the live counters on a capture pulse.
// Assumes capture is one cycle wide; the latches hold otherwise.
module cal_shadow #(
    parameter int                          BYTES   = 6,
    parameter logic [BYTES*8-1:0]          INIT    = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [BYTES*8-1:0] live,
    output logic [BYTES*8-1:0] held
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        // One latch byte per field
        always_ff @(posedge clk) begin
            if (!rst_n)       held[b*8 +: 8] <= INIT[b*8 +: 8];
            else if (capture) held[b*8 +: 8] <= live[b*8 +: 8];
        end
    end
endmodule

// File: rtl/bcd_calendar_top.sv
// Register front end of the calendar: control bits, per-field write enables,
// snapshot request and read multiplexer. Assumes a byte-wide, single-cycle
// write strobe and a combinational read.
module bcd_calendar_top
    import calendar_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    logic                  run_q, mode12_q, snap_q;
    logic                  ctrl_wr, time_wr;
    logic [NUM_FIELDS-1:0] load_en;
    cal_time_t             live_time;
    logic [SHADOW_W-1:0]   live_vec, shadow_vec;
    logic [WDAY_W-1:0]     live_wday;

    assign ctrl_wr   = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
    assign time_wr   = reg_we && !run_q;
    assign live_vec  = live_time[SHADOW_W-1:0];
    assign live_wday = live_time.wday;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_load
        assign load_en[f] = time_wr && (reg_addr == ADDR_W'(f));
    end

    // Control register; snapshot bit clears itself one cycle after being set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            mode12_q <= 1'b0;
            snap_q   <= 1'b0;
        end else if (ctrl_wr) begin
            run_q    <= reg_wdata[CTL_RUN];
            mode12_q <= reg_wdata[CTL_MODE12];
            snap_q   <= reg_wdata[CTL_SNAP];
        end else begin
            snap_q   <= 1'b0;
        end
    end

    cal_time_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (run_q && tick_1hz),
        .mode12    (mode12_q),
        .load_en   (load_en),
        .load_data (reg_wdata),
        .now       (live_time)
    );

    cal_shadow #(
        .BYTES (NUM_SHADOW),
        .INIT  (TIME_RESET[SHADOW_W-1:0])
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (snap_q),
        .live    (live_vec),
        .held    (shadow_vec)
    );

    // Read multiplexer
    always_comb begin
        reg_rdata = 8'h00;
        for (int i = 0; i < NUM_SHADOW; i++)
            if (reg_addr == ADDR_W'(i)) reg_rdata = shadow_vec[i*8 +: 8];
        if (reg_addr == ADDR_W'(OFS_WDAY)) reg_rdata = {{(8-WDAY_W){1'b0}}, live_wday};
        if (reg_addr == ADDR_W'(OFS_CTRL)) begin
            reg_rdata[CTL_RUN]    = run_q;
            reg_rdata[CTL_MODE12] = mode12_q;
            reg_rdata[CTL_SNAP]   = snap_q;
        end
        if (reg_addr == ADDR_W'(OFS_STAT)) reg_rdata[STS_RUNNING] = run_q;
    end
endmodule

// File: rtl/cal_checker.sv
// Temporal properties of the calendar counter, bound into the top module.
// Assumes the signal names of bcd_calendar_top.
module cal_checker
    import calendar_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                we,
    input logic [ADDR_W-1:0]   addr,
    input logic [7:0]          wdata,
    input logic                run,
    input logic                snap,
    input logic [SHADOW_W-1:0] live_vec,
    input logic [WDAY_W-1:0]   live_wday,
    input logic [SHADOW_W-1:0] shadow_vec
);
    AST_TICK_MOVES_SECONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (live_vec[7:0] != $past(live_vec[7:0]))); // R2

    AST_RUNNING_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> ($stable(live_vec) && $stable(live_wday))); // R8

    AST_STOPPED_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !we) |=> ($stable(live_vec) && $stable(live_wday))); // R2

    AST_SNAP_CAPTURES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (shadow_vec == $past(live_vec))); // R9

    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(shadow_vec)); // R9

    AST_SNAP_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (snap && !(we && addr == ADDR_W'(OFS_CTRL) && wdata[CTL_SNAP])) |=> !snap); // R10
endmodule

bind bcd_calendar_top cal_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_1hz),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .run        (run_q),
    .snap       (snap_q),
    .live_vec   (live_vec),
    .live_wday  (live_wday),
    .shadow_vec (shadow_vec)
);

// File: tb/bcd_calendar_top_tb_top.sv
`timescale 1ns/1ps
// Bench: an integer-arithmetic calendar model predicts reg_rdata each cycle.
module bcd_calendar_top_tb_top;
    localparam int AW = 5;
    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int n_checks = 0, n_fail = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    bcd_calendar_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .reg_we(we),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata));

    always #2.5 clk = ~clk;

    // ---------------- reference model ----------------
    int m_f[6];          // live bytes: sec, min, hour, day, month, year
    int m_sh[6];         // latches
    int m_wd;
    bit m_run, m_mode, m_snap;

    function automatic int b2i(int v); return ((v >> 4) & 15) * 10 + (v & 15); endfunction
    function automatic int i2b(int v); return ((v / 10) << 4) | (v % 10); endfunction

    function automatic int month_len(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_f = '{0, 0, 0, 1, 1, 0};
        m_sh = m_f;
        m_wd = 0; m_run = 0; m_mode = 0; m_snap = 0;
    endtask

    task automatic model_second();
        int s, mi, h24, d, mo;
        bit pm;
        s = b2i(m_f[0]) + 1;
        if (s < 60) begin m_f[0] = i2b(s); return; end
        m_f[0] = 0;
        mi = b2i(m_f[1]) + 1;
        if (mi < 60) begin m_f[1] = i2b(mi); return; end
        m_f[1] = 0;
        if (m_mode) begin
            pm  = m_f[2][7];
            h24 = (b2i(m_f[2] & 8'h7F) % 12) + (pm ? 12 : 0);
        end else h24 = b2i(m_f[2]);
        h24 = (h24 + 1) % 24;
        if (m_mode) m_f[2] = ((h24 >= 12) ? 8'h80 : 0) | i2b((h24 % 12 == 0) ? 12 : h24 % 12);
        else        m_f[2] = i2b(h24);
        if (h24 != 0) return;
        m_wd = (m_wd + 1) % 7;
        d = b2i(m_f[3]) + 1;
        if (d <= month_len(b2i(m_f[4]), b2i(m_f[5]))) begin m_f[3] = i2b(d); return; end
        m_f[3] = 1;
        mo = b2i(m_f[4]) + 1;
        if (mo <= 12) begin m_f[4] = i2b(mo); return; end
        m_f[4] = 1;
        m_f[5] = i2b((b2i(m_f[5]) + 1) % 100);
    endtask

    always @(posedge clk) begin
        bit old_run;
        if (!rst_n) model_reset();
        else begin
            old_run = m_run;
            if (m_snap) m_sh = m_f;
            if (old_run && tick) model_second();
            if (we && !old_run && addr <= 5) m_f[addr] = wdata;
            if (we && !old_run && addr == 6) m_wd = wdata & 7;
            if (we && addr == 13) begin
                m_run = wdata[0]; m_mode = wdata[3]; m_snap = wdata[6];
            end else m_snap = 0;
        end
    end

    function automatic int expect_rd(int a);
        if (a <= 5)  return m_sh[a];
        if (a == 6)  return m_wd;
        if (a == 13) return (m_snap << 6) | (m_mode << 3) | m_run;
        if (a == 14) return m_run << 1;
        return 0;
    endfunction

    // Compare read data against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (rdata !== 8'(expect_rd(int'(addr)))) begin
                n_fail++;
                $display("FAIL %s addr 0x%02h: got 0x%02h expected 0x%02h",
                         cur_req, addr, rdata, 8'(expect_rd(int'(addr))));
            end
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0] ctl = 8'h00;

    task automatic cyc(); @(posedge clk); #1; endtask
    task automatic wr(int a, int d);
        we = 1; addr = AW'(a); wdata = 8'(d); cyc(); we = 0;
    endtask
    task automatic rd(int a); addr = AW'(a); cyc(); endtask
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin tick = 1; cyc(); tick = 0; cyc(); end
    endtask
    task automatic dump();
        wr(13, ctl | 8'h40);
        rd(13);
        for (int a = 0; a <= 6; a++) rd(a);
        rd(13); rd(14);
    endtask
    task automatic load(int s, int mi, int h, int d, int mo, int y, int w, bit m12);
        ctl = m12 ? 8'h08 : 8'h00;
        wr(13, ctl);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, d); wr(4, mo); wr(5, y); wr(6, w);
        ctl = ctl | 8'h01;
        wr(13, ctl);
    endtask

    initial begin
        repeat (4) cyc();
        rst_n = 1; cur_req = "R1";
        for (int a = 0; a < 32; a++) rd(a);          // R1 reset values, R11 unused offsets
        cur_req = "R2"; ticks(3); dump();              // stopped: no count
        load(8'h58, 8'h59, 8'h04, 8'h10, 8'h03, 8'h21, 2, 0);
        ticks(3); dump();                              // R2 minute and hour carry
        cur_req = "R3"; load(8'h59, 8'h59, 8'h23, 8'h15, 8'h07, 8'h30, 3, 0);
        ticks(1); dump();
        cur_req = "R4"; load(8'h59, 8'h59, 8'h11, 8'h05, 8'h05, 8'h05, 1, 1);
        ticks(1); dump();                              // 11 AM -> 12 PM
        load(8'h59, 8'h59, 8'h91, 8'h05, 8'h05, 8'h05, 1, 1);
        ticks(1); dump();                              // 11 PM -> 12 AM, next day
        load(8'h59, 8'h59, 8'h92, 8'h05, 8'h05, 8'h05, 1, 1);
        ticks(1); dump();                              // 12 PM -> 01 PM
        cur_req = "R5";
        load(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h22, 0, 0); ticks(1); dump();
        load(8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h22, 0, 0); ticks(1); dump();
        load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 0, 0); ticks(1); dump();
        load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 0, 0); ticks(1); dump();
        ticks(3600 * 24); dump();                      // Feb 29 -> Mar 1
        load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00, 0, 0); ticks(1); dump();
        load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h90, 0, 0); ticks(1); dump();
        cur_req = "R6"; load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 5, 0);
        ticks(1); dump();
        cur_req = "R7"; load(8'h59, 8'h59, 8'h23, 8'h11, 8'h11, 8'h11, 6, 0);
        ticks(1); dump();
        cur_req = "R8";
        wr(0, 8'h33); wr(6, 8'h04); dump();            // ignored while running
        wr(13, 8'h00); wr(0, 8'h42); wr(6, 8'hFF); dump();
        cur_req = "R9";
        load(8'h59, 8'h59, 8'h10, 8'h01, 8'h01, 8'h01, 0, 0);
        wr(13, ctl | 8'h40);                           // snapshot pending
        tick = 1; cyc(); tick = 0;                     // tick meets capture edge
        for (int a = 0; a <= 5; a++) rd(a);
        ticks(5);
        for (int a = 0; a <= 5; a++) rd(a);            // latches held
        dump();
        cur_req = "R10"; wr(13, 8'h49); rd(13); rd(13);
        cur_req = "R11"; rd(14); wr(13, 8'h00); rd(14); rd(15); rd(31);
        cur_req = "R2";                                // tick with stop write
        load(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 0, 0);
        we = 1; addr = AW'(13); wdata = 8'h00; tick = 1; cyc(); we = 0; tick = 0;
        ticks(2); dump();
        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule